// File: doc/BRIEF.md
# I2C Channel-Select Controller for a Four-Way Bus Switch

This block is the digital half of a four-way downstream bus switch. It is an I2C target that owns one 8-bit control register. The value written into that register chooses which one of four downstream channels the upstream bus is joined to, or joins none of them. The block takes SCL and SDA after they have been synchronised to the system clock. It first filters out short glitches on both lines. It then finds START and STOP conditions, receives the 7-bit address and acknowledges it, and pulls SDA low through an open-drain enable to send acknowledges and read data.

A master writes the control byte in a write transfer. The new choice is held back and reaches the channel-enable outputs only at the next STOP, when every downstream line is idle-high. A read transfer returns the stored selection in the low bits. The upper nibble carries the state of the four active-low interrupt inputs, sampled at the moment each read byte is loaded. The channel-enable outputs form a vector that is one-hot or all zero.

The block has no data stream at its edge. Every pin is a plain control or status line, so no valid/ready rules apply.

Top module: `chan_mux_ctrl`

## Requirements
- R1: The target answers the address 1,1,1,0,A2,A1,A0, taken from the three address pins and sent MSB first. It is followed by a direction bit, where 1 means read and 0 means write. On a match the target pulls SDA low through the ninth (acknowledge) clock.
- R2: After an address that does not match, the target never pulls SDA, and any later bytes change neither the register nor the channel outputs until the next START.
- R3: Every data byte of a write is acknowledged. When several bytes are written in one transfer, only the last one stays in the register.
- R4: Control bit 2 is the enable and bits 1:0 give the channel number. The output is `chan_en_o[n]` = 1 only for n = bits 1:0 when bit 2 is 1, and all outputs are 0 when bit 2 is 0. At most one output is ever high.
- R5: A written selection leaves the channel outputs unchanged until a STOP is detected, and it drives them after that STOP.
- R6: A read byte is {~irq_n_i[3:0], 0, reg[2:0]}. Bit 7..4 is 1 when the matching interrupt input is low, and reg is the last written value. Written bits 7:3 are discarded and bit 3 always reads 0. The interrupt state is taken when the byte is loaded for sending.
- R7: If the master acknowledges a read byte, the next byte is sent. If it NACKs, the target releases SDA. SDA is released whenever a STOP is seen.
- R8: A synchronous reset clears the register and the applied selection to zero, disables every channel and releases SDA.
- R9: Pulses on SCL or SDA that last fewer than FILT_CYC clock cycles are ignored.
- R10: A START that arrives in the middle of a transfer (a repeated START) abandons the partial transfer and begins a new address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| addr_pins_i | input | 3 | Static address pins A2..A0 |
| irq_n_i | input | 4 | Active-low interrupt inputs of channels 3..0 |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| chan_en_o | output | 4 | Channel enables, one-hot or zero |

## Verification
The bench builds the block with FILT_CYC = 3 instead of the default of 13. This makes a two-cycle glitch short enough to be rejected while bus phases of twelve clocks still pass cleanly, so glitch suppression can be tested without long bit times. The same setting keeps each transfer to a few hundred cycles. That leaves room to cover every enable/channel combination, discarded upper write bits, multi-byte writes, two-byte reads ending in a NACK, repeated STARTs after a partial byte, a non-matching address, and a reset in mid-configuration.

// File: rtl/chmux_pkg.sv
package chmux_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SEL_W  = CH_W + 1;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W + 1);
  localparam logic [3:0] ADDR_FIXED = 4'b1110;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } bus_st_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/chmux_deglitch.sv
module chmux_deglitch #(
  parameter int FILT_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic in_i,
  output logic out_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (in_i == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      out_q <= in_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign out_o = out_q;

  // R9: the filtered level only moves toward the raw level
  a_r9_follows_input: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_q) |-> (out_q == $past(in_i)));
endmodule

// File: rtl/chmux_busev.sv
module chmux_busev
  import chmux_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_f,
  input  logic    sda_f,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    ev_o.start = scl_f & scl_q & sda_q & ~sda_f;
    ev_o.stop  = scl_f & scl_q & ~sda_q & sda_f;
    ev_o.rise  = scl_f & ~scl_q;
    ev_o.fall  = ~scl_f & scl_q;
    ev_o.sda   = sda_f;
  end
endmodule

// File: rtl/chmux_engine.sv
module chmux_engine
  import chmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_ev_t           ev_i,
  input  logic [2:0]        addr_pins_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              wr_stb_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic              sda_pull_o
);
  localparam logic [BIT_CW-1:0] LAST_RX = BIT_CW'(BYTE_W);
  localparam logic [BIT_CW-1:0] LAST_TX = BIT_CW'(BYTE_W - 1);

  bus_st_t           state_q;
  logic [BIT_CW-1:0] cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, mack_q, pull_q, stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (ev_i.stop) begin
        state_q <= S_IDLE;
        pull_q  <= 1'b0;
      end else if (ev_i.start) begin
        state_q <= S_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          S_ADDR: begin
            if (ev_i.rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], ev_i.sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_i.fall && cnt_q == LAST_RX) begin
              if (sh_q[BYTE_W-1:1] == {ADDR_FIXED, addr_pins_i}) begin
                rw_q    <= sh_q[0];
                pull_q  <= 1'b1;
                state_q <= S_AACK;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (ev_i.fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q    <= rd_byte_i;
                pull_q  <= ~rd_byte_i[BYTE_W-1];
                state_q <= S_RDAT;
              end else begin
                pull_q  <= 1'b0;
                state_q <= S_WDAT;
              end
            end
          end
          S_WDAT: begin
            if (ev_i.rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], ev_i.sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_i.fall && cnt_q == LAST_RX) begin
              stb_q   <= 1'b1;
              pull_q  <= 1'b1;
              state_q <= S_WACK;
            end
          end
          S_WACK: begin
            if (ev_i.fall) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (ev_i.fall) begin
              if (cnt_q == LAST_TX) begin
                pull_q  <= 1'b0;
                state_q <= S_RACK;
              end else begin
                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                pull_q <= ~sh_q[BYTE_W-2];
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          S_RACK: begin
            if (ev_i.rise) begin
              mack_q <= ~ev_i.sda;
            end else if (ev_i.fall) begin
              if (mack_q) begin
                sh_q    <= rd_byte_i;
                pull_q  <= ~rd_byte_i[BYTE_W-1];
                cnt_q   <= '0;
                state_q <= S_RDAT;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_stb_o   = stb_q;
  assign wr_sel_o   = sh_q[SEL_W-1:0];
  assign sda_pull_o = pull_q;

  // R2: an idle target never drives the bus
  a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !sda_pull_o);
  // R7: a STOP always frees SDA and returns to idle
  a_r7_stop_releases: assert property (@(posedge clk) disable iff (rst)
    ev_i.stop |=> (!sda_pull_o && state_q == S_IDLE));
  // R3: while acknowledging a written byte the line is held low
  a_r3_write_ack_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WACK) |-> sda_pull_o);
endmodule

// File: rtl/chmux_ctrl.sv
module chmux_ctrl
  import chmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              stop_i,
  output logic [SEL_W-1:0]  ctrl_o,
  output logic [NUM_CH-1:0] chan_en_o
);
  logic [SEL_W-1:0] ctrl_q, act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_stb_i) ctrl_q <= wr_sel_i;
      if (stop_i)   act_q  <= ctrl_q;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign chan_en_o[n] = act_q[CH_W] && (act_q[CH_W-1:0] == CH_W'(n));
  end

  assign ctrl_o = ctrl_q;

  // R5: the applied selection only moves on a STOP
  a_r5_hold_until_stop: assert property (@(posedge clk) disable iff (rst)
    !stop_i |=> $stable(act_q));
  // R4: never more than one channel joined
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_en_o));
  // R8: reset leaves everything cleared
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (act_q == '0 && ctrl_q == '0));
endmodule

// File: rtl/chan_mux_ctrl.sv
module chan_mux_ctrl
  import chmux_pkg::*;
#(
  parameter int FILT_CYC = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_pins_i,
  input  logic [3:0] irq_n_i,
  output logic       sda_pull_o,
  output logic [3:0] chan_en_o
);
  logic [1:0]        raw, filt;
  bus_ev_t           ev;
  logic              wr_stb;
  logic [SEL_W-1:0]  wr_sel, ctrl;
  logic [BYTE_W-1:0] rd_byte;

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < 2; l++) begin : g_filt
    chmux_deglitch #(.FILT_CYC(FILT_CYC)) u_dg (
      .clk(clk), .rst(rst), .in_i(raw[l]), .out_o(filt[l])
    );
  end

  chmux_busev u_ev (
    .clk(clk), .rst(rst), .scl_f(filt[1]), .sda_f(filt[0]), .ev_o(ev)
  );

  assign rd_byte = {~irq_n_i, {(BYTE_W - NUM_CH - SEL_W){1'b0}}, ctrl};

  chmux_engine u_eng (
    .clk(clk), .rst(rst), .ev_i(ev), .addr_pins_i(addr_pins_i),
    .rd_byte_i(rd_byte), .wr_stb_o(wr_stb), .wr_sel_o(wr_sel),
    .sda_pull_o(sda_pull_o)
  );

  chmux_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_stb_i(wr_stb), .wr_sel_i(wr_sel),
    .stop_i(ev.stop), .ctrl_o(ctrl), .chan_en_o(chan_en_o)
  );
endmodule

// File: tb/tb_chan_mux_ctrl.sv
module tb_chan_mux_ctrl;
  localparam int FILT = 3;
  localparam int Q = 12;
  localparam int H = 4;
  localparam logic [2:0] APINS = 3'b101;
  localparam logic [7:0] AW = {4'b1110, APINS, 1'b0};
  localparam logic [7:0] AR = {4'b1110, APINS, 1'b1};
  // data[15:8], irq_n[7:4], expected channel enables[3:0]
  localparam logic [15:0] VEC [6] = '{
    {8'h04, 4'hF, 4'b0001}, {8'h05, 4'hE, 4'b0010}, {8'h06, 4'h5, 4'b0100},
    {8'h07, 4'h0, 4'b1000}, {8'hFB, 4'hA, 4'b0000}, {8'h3E, 4'h7, 4'b0100}
  };

  logic clk = 0, rst = 1, scl = 1, sda_m = 1;
  logic [3:0] irq_n = 4'hF;
  logic sda_pull;
  logic [3:0] chan_en;
  wire sda_line = sda_m & ~sda_pull;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chan_mux_ctrl #(.FILT_CYC(FILT)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .addr_pins_i(APINS), .irq_n_i(irq_n), .sda_pull_o(sda_pull), .chan_en_o(chan_en)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl = 1; wt(Q); sda_m = 0; wt(Q); scl = 0;
  endtask

  task automatic bus_rstart();
    wt(H); sda_m = 1; wt(Q); scl = 1; wt(Q); sda_m = 0; wt(Q); scl = 0;
  endtask

  task automatic bus_stop();
    wt(H); sda_m = 0; wt(Q); scl = 1; wt(Q); sda_m = 1; wt(Q);
  endtask

  task automatic send_bit(logic b);
    wt(H); sda_m = b; wt(Q); scl = 1; wt(Q); scl = 0;
  endtask

  task automatic recv_bit(output logic b);
    wt(H); sda_m = 1; wt(Q); scl = 1; wt(Q / 2); b = sda_line; wt(Q / 2); scl = 0;
  endtask

  task automatic send_byte(logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  // send a byte with a short SCL pulse in bit 5's low phase and a
  // short SDA pulse while SCL is high in bit 2
  task automatic send_byte_glitchy(logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (i == 5) begin
        wt(H); sda_m = d[i]; wt(2); scl = 1; wt(FILT - 1); scl = 0;
        wt(Q - 2 - (FILT - 1)); scl = 1; wt(Q); scl = 0;
      end else if (i == 2) begin
        wt(H); sda_m = d[i]; wt(Q); scl = 1; wt(3);
        sda_m = ~d[i]; wt(FILT - 1); sda_m = d[i]; wt(Q - 3 - (FILT - 1)); scl = 0;
      end else begin
        send_bit(d[i]);
      end
    end
    recv_bit(a);
    acked = ~a;
  endtask

  initial begin
    logic ack;
    logic [7:0] rd, rd2, exp_rd;
    logic [3:0] prev_ch;

    // R8: reset state
    wt(4);
    chk("R8 reset chan_en", {4'h0, chan_en}, 8'h00);
    chk("R8 reset sda released", {7'h0, sda_pull}, 8'h00);
    rst = 0;
    wt(Q);

    // table walk: R1 R3 R4 R5 R6
    prev_ch = 4'b0000;
    foreach (VEC[k]) begin
      irq_n = VEC[k][7:4];
      bus_start();
      send_byte(AW, ack);
      chk("R1 write address ack", {7'h0, ack}, 8'h01);
      send_byte(VEC[k][15:8], ack);
      chk("R3 data ack", {7'h0, ack}, 8'h01);
      wt(Q);
      chk("R5 outputs held before STOP", {4'h0, chan_en}, {4'h0, prev_ch});
      bus_stop();
      chk("R4 R5 chan_en after STOP", {4'h0, chan_en}, {4'h0, VEC[k][3:0]});
      prev_ch = VEC[k][3:0];
      bus_start();
      send_byte(AR, ack);
      chk("R1 read address ack", {7'h0, ack}, 8'h01);
      recv_byte(1'b0, rd);
      exp_rd = {~VEC[k][7:4], 1'b0, VEC[k][10:8]};
      chk("R6 read byte", rd, exp_rd);
      wt(8);
      chk("R7 released after NACK", {7'h0, sda_pull}, 8'h00);
      bus_stop();
    end

    // R2: wrong address ignored
    irq_n = 4'hF;
    bus_start();
    send_byte({4'b1110, 3'b100, 1'b0}, ack);
    chk("R2 no ack on mismatch", {7'h0, ack}, 8'h00);
    send_byte(8'h05, ack);
    chk("R2 no ack on later byte", {7'h0, ack}, 8'h00);
    bus_stop();
    chk("R2 chan_en unchanged", {4'h0, chan_en}, 8'h04);
    bus_start();
    send_byte(AR, ack);
    recv_byte(1'b0, rd);
    bus_stop();
    chk("R2 register unchanged", rd, 8'h06);

    // R3: several bytes, last one kept
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h04, ack);
    send_byte(8'h05, ack);
    send_byte(8'h07, ack);
    chk("R3 third byte ack", {7'h0, ack}, 8'h01);
    bus_stop();
    chk("R3 last byte applied", {4'h0, chan_en}, 8'h08);

    // R7: two-byte read, ACK then NACK
    bus_start();
    send_byte(AR, ack);
    recv_byte(1'b1, rd);
    recv_byte(1'b0, rd2);
    chk("R7 first read byte", rd, 8'h07);
    chk("R7 second read byte after ACK", rd2, 8'h07);
    wt(8);
    chk("R7 released after final NACK", {7'h0, sda_pull}, 8'h00);
    bus_stop();

    // R10: repeated START after a partial byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_rstart();
    send_byte(AW, ack);
    chk("R10 address ack after repeated START", {7'h0, ack}, 8'h01);
    send_byte(8'h06, ack);
    bus_stop();
    chk("R10 selection after repeated START", {4'h0, chan_en}, 8'h04);

    // R9: glitches on SCL and SDA rejected
    bus_start();
    send_byte(AW, ack);
    send_byte_glitchy(8'h05, ack);
    chk("R9 ack despite glitches", {7'h0, ack}, 8'h01);
    bus_stop();
    chk("R9 selection unaffected by glitches", {4'h0, chan_en}, 8'h02);

    // R8: reset in the middle of a configuration
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h07, ack);
    bus_stop();
    chk("R8 pre-reset selection", {4'h0, chan_en}, 8'h08);
    rst = 1; wt(3); rst = 0; wt(2);
    chk("R8 reset clears outputs", {4'h0, chan_en}, 8'h00);
    bus_start();
    send_byte(AR, ack);
    recv_byte(1'b0, rd);
    bus_stop();
    chk("R8 R6 register cleared by reset", rd, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule